// File: doc/BRIEF.md
# Daisy-Chainable SPI Command Receiver

This block is the slave serial front end of a small configurable peripheral. While chip select is low it shifts a 16-bit command word in from the serial data input on each rising serial clock edge. The bit that falls off the top of its shift register goes out on the serial data output, so several devices can share one chip select and one clock, with each device's output wired to the next device's input. Serial clock, data and chip select are brought into the faster system clock through two-flop synchronizers, and all edge detection happens in that domain.

When chip select rises, the block classifies the frame by the number of clocked bits. A whole number of words executes the word that was shifted in last. A count that is a multiple of four but not of sixteen is carried into the next chip-select window. Any other count is discarded. A chip-select pulse with no clock edges replays the last executed command. An executed command reaches the downstream register block as a one-cycle strobe with its command, address and data fields. Readback commands make the block load a value from the register block into its shift register, and that value is shifted out during the next frame. The serial output is open drain and is modelled as a pull-low enable.

Top module: `spi_cmd_rx`

## Requirements
- R1: A word is 16 bits, sent most significant bit first. Word bits 15:12 are the command, bits 11:8 are the address and bits 7:0 are the data. An executed word appears on `cmd`, `addr` and `data` exactly as shifted in.
- R2: Nothing is decoded while chip select is low. `cmd_valid` rises only after a chip-select rising edge and stays high for exactly one system clock.
- R3: If the count of rising serial clock edges in the current window, plus any carried count, is a nonzero multiple of 16 at the chip-select rise, the last 16 bits shifted in execute and the bit counter returns to zero. A 32-bit frame executes only its final 16 bits.
- R4: If the count at the chip-select rise is not a multiple of 4 (for example 15 or 17), no strobe is issued and the counter is cleared. The shift register keeps its contents, and they are what shifts out on the serial output in the next frame.
- R5: If the count at the chip-select rise is a multiple of 4 but not of 16, no strobe is issued and the count is carried into the next window. For example, two 8-bit windows together execute one 16-bit word.
- R6: A chip-select low-then-high pulse with no rising serial clock edge replays the last executed word, with the same fields. If no word has executed since reset, the pulse does nothing.
- R7: `sdo_oe` pulls the serial line low only while chip select is low and the shift register's top bit is 0. Otherwise the line floats high. A device therefore delays the bit stream by 16 clocks, and when two devices are chained, the first 16 bits of a 32-bit frame land in the far device.
- R8: Command code 0 executes without a strobe, whether it arrives in a frame or through a replay.
- R9: Command codes 9 and 10 are strobed normally. In the strobe cycle, `rdbk_data` is loaded into the shift register, and it shifts out most significant bit first during the next frame.
- R10: Both serial clock modes work: clock idling low and clock idling high. In each, data is sampled on the rising serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo_oe | output | 1 | Serial output pull-low enable (1 = drive line to 0) |
| cmd_valid | output | 1 | One-cycle strobe for an executed command |
| cmd | output | 4 | Command field of the executed word |
| addr | output | 4 | Address field of the executed word |
| data | output | 8 | Data field of the executed word |
| rdbk_data | input | 16 | Readback value, sampled during a strobe with command 9 or 10 |

## Verification
Assertions check the following on every cycle: the strobe is one cycle wide and follows a chip-select rise, command 0 never strobes, and a discarded count reads zero after the frame while a carried count is unchanged. They also check that a replay leaves the fields unchanged, that the shift register is frozen when neither shifting nor loading, that the output is released with chip select high, and that a readback load captures `rdbk_data`. Only the bench scenarios can show the end-to-end properties. These are the mapping of a whole serial frame onto the fields in both clock modes, the 16-bit delay through two chained devices, retention of shifted data across discarded frames, and the exact readback bit stream on the serial line.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int GROUP_W = 4;
  localparam int CNT_W   = 8;

  localparam logic [CMD_W-1:0] OP_NOP    = 4'd0;
  localparam logic [CMD_W-1:0] OP_RD_SET = 4'd9;
  localparam logic [CMD_W-1:0] OP_RD_MEM = 4'd10;

  typedef enum logic [1:0] {FR_EXEC, FR_HOLD, FR_DROP, FR_REPEAT} frame_cls_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;

  // Decide what a chip-select rise does with the accumulated bit count.
  function automatic frame_cls_e classify(input logic clocked, input logic [CNT_W-1:0] cnt);
    if (!clocked)                      return FR_REPEAT;
    if ((int'(cnt) % WORD_W) == 0)     return FR_EXEC;
    if ((int'(cnt) % GROUP_W) == 0)    return FR_HOLD;
    return FR_DROP;
  endfunction

  function automatic logic [CNT_W-1:0] count_after(input frame_cls_e cls, input logic [CNT_W-1:0] cnt);
    return (cls == FR_EXEC || cls == FR_DROP) ? '0 : cnt;
  endfunction

  function automatic logic is_readback(input logic [CMD_W-1:0] c);
    return (c == OP_RD_SET) || (c == OP_RD_MEM);
  endfunction

  function automatic cmd_word_t split_word(input logic [WORD_W-1:0] w);
    return cmd_word_t'(w);
  endfunction
endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic sdi_pin,
  input  logic cs_n_pin,
  output logic sclk_rise,
  output logic cs_rise,
  output logic cs_low,
  output logic sdi_s
);
  localparam int NPIN = 3;
  // bit order {cs_n, sclk, sdi}; idle has chip select high
  localparam logic [NPIN-1:0] IDLE = 3'b100;

  logic [NPIN-1:0] stg [STAGES];
  logic [NPIN-1:0] now_v;
  logic [NPIN-1:0] prev_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
      prev_v <= IDLE;
    end else begin
      stg[0] <= {cs_n_pin, sclk_pin, sdi_pin};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_v <= now_v;
    end
  end

  assign now_v     = stg[STAGES-1];
  assign sclk_rise = now_v[1] & ~prev_v[1];
  assign cs_rise   = now_v[2] & ~prev_v[2];
  assign cs_low    = ~now_v[2];
  assign sdi_s     = now_v[0];

  // R2: a chip-select rise is seen only one cycle after chip select was low
  p_cs_rise_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> $past(cs_low));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         cs_low,
  output logic [W-1:0] sreg,
  output logic         sdo_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      sdo_oe <= 1'b0;
    end else begin
      if (load_en)       sreg <= load_val;
      else if (shift_en) sreg <= {sreg[W-2:0], bit_in};
      sdo_oe <= cs_low & ~sreg[W-1];
    end
  end

  // R4: outside shifting and loading the register holds its contents
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_en) |=> $stable(sreg));
  // R1: each new bit enters at the bottom
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> sreg[0] == $past(bit_in));
  // R7: line released once chip select is high
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> !sdo_oe);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              cs_rise,
  input  logic              cs_low,
  input  logic [WORD_W-1:0] word,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic             bit_evt;
  logic             clocked;
  logic [CNT_W-1:0] bit_cnt;
  logic             have_last;
  cmd_word_t        last_q;
  cmd_word_t        incoming;
  frame_cls_e       cls;

  assign bit_evt  = sclk_rise & cs_low;
  assign incoming = split_word(word);
  assign cls      = classify(clocked, bit_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clocked   <= 1'b0;
      bit_cnt   <= '0;
      have_last <= 1'b0;
      last_q    <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (bit_evt) begin
        bit_cnt <= bit_cnt + 1'b1;
        clocked <= 1'b1;
      end
      if (cs_rise) begin
        clocked <= 1'b0;
        bit_cnt <= count_after(cls, bit_cnt);
        case (cls)
          FR_EXEC: begin
            last_q    <= incoming;
            have_last <= 1'b1;
            cmd_valid <= (incoming.cmd != OP_NOP);
          end
          FR_REPEAT: cmd_valid <= have_last && (last_q.cmd != OP_NOP);
          default:   cmd_valid <= 1'b0;
        endcase
      end
    end
  end

  assign cmd  = last_q.cmd;
  assign addr = last_q.addr;
  assign data = last_q.data;

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_strobe_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise));
  p_exec_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_EXEC) |=> {cmd, addr, data} == $past(word));
  p_exec_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_EXEC) |=> bit_cnt == '0);
  p_odd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_DROP) |=> (bit_cnt == '0 && !cmd_valid));
  p_carry_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_HOLD) |=> ($stable(bit_cnt) && !cmd_valid));
  p_replay_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_REPEAT) |=> $stable({cmd, addr, data}));
  p_replay_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cls == FR_REPEAT && !have_last) |=> !cmd_valid);
  p_nop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd != OP_NOP);
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo_oe,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  input  logic [WORD_W-1:0] rdbk_data
);
  logic              sclk_rise;
  logic              cs_rise;
  logic              cs_low;
  logic              sdi_s;
  logic              shift_en;
  logic              load_en;
  logic [WORD_W-1:0] shift_word;

  spi_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .sdi_pin(sdi), .cs_n_pin(cs_n),
    .sclk_rise(sclk_rise), .cs_rise(cs_rise), .cs_low(cs_low), .sdi_s(sdi_s)
  );

  assign shift_en = sclk_rise & cs_low;
  assign load_en  = cmd_valid & is_readback(cmd);

  spi_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sdi_s),
    .load_en(load_en), .load_val(rdbk_data), .cs_low(cs_low),
    .sreg(shift_word), .sdo_oe(sdo_oe)
  );

  spi_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_rise(cs_rise),
    .cs_low(cs_low), .word(shift_word), .cmd_valid(cmd_valid),
    .cmd(cmd), .addr(addr), .data(data)
  );

  // R9: a readback strobe captures the register block's value
  p_readback_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> shift_word == $past(rdbk_data));
endmodule

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;
  localparam logic [15:0] RDBK = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo_oe, cmd_valid;
  logic [3:0] cmd, addr;
  logic [7:0] data;
  logic far_oe, far_valid;
  logic [3:0] far_cmd, far_addr;
  logic [7:0] far_data;
  logic near_line;

  int total = 0;
  int bad = 0;
  int near_pulses = 0, far_pulses = 0, run = 0, max_run = 0;
  logic [15:0] near_cap = '0, far_cap = '0;
  logic [15:0] model_sr = '0;
  logic [63:0] rx_bits = '0;

  always #10 clk = ~clk;

  assign near_line = sdo_oe ? 1'b0 : 1'b1;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo_oe(sdo_oe), .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr),
    .data(data), .rdbk_data(RDBK)
  );

  spi_cmd_rx i_far (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(near_line),
    .sdo_oe(far_oe), .cmd_valid(far_valid), .cmd(far_cmd), .addr(far_addr),
    .data(far_data), .rdbk_data(16'h0000)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      near_pulses++;
      run++;
      if (run > max_run) max_run = run;
      near_cap = {cmd, addr, data};
    end else run = 0;
    if (rst_n && far_valid) begin
      far_pulses++;
      far_cap = {far_cmd, far_addr, far_data};
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic shift_frame(input logic [63:0] bits, input int n, input int mode,
                             input bit keep_low, input string sdo_req);
    int mism = 0;
    sclk = (mode == 3);
    #40;
    cs_n = 1'b0;
    #200;
    rx_bits = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdi = bits[i];
      #200;
      rx_bits = {rx_bits[62:0], near_line};
      if (near_line !== model_sr[15]) mism++;
      model_sr = {model_sr[14:0], bits[i]};
      sclk = 1'b1;
      #200;
    end
    if (mode == 0) sclk = 1'b0;
    #200;
    if (!keep_low) begin
      cs_n = 1'b1;
      #600;
    end
    check(mism == 0, sdo_req, "serial output stream mismatches", mism, 0);
  endtask

  task automatic pulse_cs();
    cs_n = 1'b0;
    #200;
    cs_n = 1'b1;
    #600;
  endtask

  task automatic t_reset();
    check(cmd_valid == 1'b0, "R2", "strobe after reset", cmd_valid, 0);
    check(sdo_oe == 1'b0, "R7", "sdo released after reset", sdo_oe, 0);
  endtask

  task automatic t_fresh_pulse();
    int p0 = near_pulses;
    pulse_cs();
    check(near_pulses == p0, "R6", "replay with no history", near_pulses - p0, 0);
  endtask

  task automatic t_exec_mode0();
    int p0 = near_pulses;
    shift_frame(64'h357E, 16, 0, 1'b1, "R7");
    check(near_pulses == p0, "R2", "no decode while cs low", near_pulses - p0, 0);
    cs_n = 1'b1;
    #600;
    check(near_pulses == p0 + 1, "R3", "16-bit frame strobes", near_pulses - p0, 1);
    check(near_cap == 16'h357E, "R1", "fields of word", near_cap, 16'h357E);
  endtask

  task automatic t_exec_mode3();
    int p0 = near_pulses;
    shift_frame(64'h62C1, 16, 3, 1'b0, "R10");
    check(near_pulses == p0 + 1, "R10", "clock-idle-high frame strobes", near_pulses - p0, 1);
    check(near_cap == 16'h62C1, "R10", "clock-idle-high fields", near_cap, 16'h62C1);
  endtask

  task automatic t_replay();
    int p0 = near_pulses;
    near_cap = '0;
    pulse_cs();
    check(near_pulses == p0 + 1, "R6", "replay strobe count", near_pulses - p0, 1);
    check(near_cap == 16'h62C1, "R6", "replay fields", near_cap, 16'h62C1);
  endtask

  task automatic t_bad_counts();
    int p0 = near_pulses;
    shift_frame(64'h1234, 15, 0, 1'b0, "R7");
    check(near_pulses == p0, "R4", "15-bit frame ignored", near_pulses - p0, 0);
    shift_frame(64'h1ABCD, 17, 0, 1'b0, "R4");
    check(near_pulses == p0, "R4", "17-bit frame ignored", near_pulses - p0, 0);
    shift_frame(64'h4199, 16, 0, 1'b0, "R4");
    check(near_pulses == p0 + 1, "R4", "count cleared, next word runs", near_pulses - p0, 1);
    check(near_cap == 16'h4199, "R4", "word after cleared count", near_cap, 16'h4199);
  endtask

  task automatic t_split();
    int p0 = near_pulses;
    shift_frame(64'h52, 8, 0, 1'b0, "R5");
    check(near_pulses == p0, "R5", "8-bit window carries", near_pulses - p0, 0);
    shift_frame(64'h3C, 8, 3, 1'b0, "R5");
    check(near_pulses == p0 + 1, "R5", "second window completes word", near_pulses - p0, 1);
    check(near_cap == 16'h523C, "R5", "joined word fields", near_cap, 16'h523C);
  endtask

  task automatic t_nop();
    int p0 = near_pulses;
    shift_frame(64'h0755, 16, 0, 1'b0, "R7");
    check(near_pulses == p0, "R8", "nop frame silent", near_pulses - p0, 0);
    pulse_cs();
    check(near_pulses == p0, "R8", "nop replay silent", near_pulses - p0, 0);
  endtask

  task automatic t_readback(input logic [3:0] op);
    int p0 = near_pulses;
    logic [15:0] w = {op, 4'h1, 8'h00};
    shift_frame({48'h0, w}, 16, 0, 1'b0, "R7");
    check(near_pulses == p0 + 1, "R9", "readback strobe", near_pulses - p0, 1);
    check(near_cap == w, "R9", "readback fields", near_cap, w);
    model_sr = RDBK;
    shift_frame(64'h0000, 16, 0, 1'b0, "R9");
    check(rx_bits[15:0] == RDBK, "R9", "readback bits on line", rx_bits[15:0], RDBK);
  endtask

  task automatic t_daisy();
    int p0 = near_pulses;
    int f0 = far_pulses;
    shift_frame(64'h8E0F_246B, 32, 0, 1'b0, "R7");
    check(near_pulses == p0 + 1, "R3", "near strobes once on 32 bits", near_pulses - p0, 1);
    check(near_cap == 16'h246B, "R3", "near keeps last word", near_cap, 16'h246B);
    check(far_pulses == f0 + 1, "R7", "far strobes once", far_pulses - f0, 1);
    check(far_cap == 16'h8E0F, "R7", "far gets first word", far_cap, 16'h8E0F);
  endtask

  task automatic t_release();
    check(sdo_oe == 1'b0, "R7", "near released with cs high", sdo_oe, 0);
    check(far_oe == 1'b0, "R7", "far released with cs high", far_oe, 0);
    check(max_run == 1, "R2", "strobe width", max_run, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #103;
    rst_n = 1'b1;
    #200;
    t_reset();
    t_fresh_pulse();
    t_exec_mode0();
    t_exec_mode3();
    t_replay();
    t_bad_counts();
    t_split();
    t_nop();
    t_readback(4'd9);
    t_readback(4'd10);
    t_daisy();
    t_release();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule